// File: doc/BRIEF.md
# Shift-Register Handshake Host Interface

This block sits between a host processor and a byte-serial peripheral link. The host sees sixteen byte-wide registers in an interface-adapter layout. Each host access is one cycle; reads return data in the same cycle, and writes and access side effects take hold at the clock edge. Timers, port A, the data-direction registers and the peripheral control register are plain storage. The shift register, port B, the auxiliary control register, the interrupt flag register and the interrupt enable register together run a software-paced byte transfer.

The host frames a transfer with an active-low in-progress bit on port B and paces the bytes by toggling an acknowledge bit. In the outbound direction each step appends the shift register contents to a command buffer. When the transfer closes with at least one byte stored, an internal responder decodes the command. After a fixed latency it posts a short reply. The host then replays the reply through the shift register in the inbound direction. Every step and every reply raises the shift flag. The interrupt line follows the flag summary, gated by the global enable.

Top module: `shift_handshake_host`

## Requirements
- R1: The register index is address bits 12:9. Indices 1 to 9, 11, 12, 14 and 15 read back the last byte written to them. Other indices are not disturbed by those writes.
- R2: After reset, port B (index 0) reads 0x28 and the flag register (index 13) and shift register (index 10) read 0x00. The interrupt output is low.
- R3: Writing the flag register clears each of bits 6:0 written as one. Bit 7 of the flag register always reads as the OR of bits 6:0.
- R4: Any read or write at the shift register index clears flag bit 2.
- R5: The interrupt output is high exactly while flag bit 7 is set and bit 7 of the last value written to the enable register (index 14) is set.
- R6: Auxiliary control (index 11) bit 4 set selects outbound. An outbound step appends the current shift register byte to the command buffer, sets flag bit 2 and sets port B bit 3.
- R7: A port B write whose bit 5 differs from the stored bit 5 opens a transfer (bit 5 low) or closes it (bit 5 high). A transfer opening resets both byte offsets to zero and performs the first step. Otherwise, a change of bit 4 alone performs one step, and a write that changes neither bit performs none.
- R8: Closing a transfer with at least one stored command byte starts the responder. RESP_LAT cycles later, port B bit 3 reads 0, flag bit 2 is set and the shift register reads 0x00.
- R9: An inbound step (bit 4 clear) loads the next reply byte into the shift register and sets flag bit 2. Port B bit 3 reads 1 once the last reply byte has been loaded.
- R10: A query command (first byte 0x00, second byte bits 3:2 = 11) gets the reply {0x00, 0x00, second byte}. If the second byte's bits 7:4 match the keyboard address, the reply is instead {0x01, 0x01, second byte, 0x01, 0x01}. The keyboard address starts at KBD_INIT.
- R11: A relocate command {0x00, second byte with bits 3:2 = 10 and bits 7:4 = keyboard address, 0x6N, 0xFE} moves the keyboard address to N and gets an empty reply.
- R12: An inbound step past the end of the reply loads 0x00 and sets port B bit 7. That bit stays set until reset. Neither the reply offset nor the command buffer ever runs past its end.
- R13: Port B bits 3 and 7 ignore host writes. The other port B bits hold the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host byte address; bits 12:9 select the register |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle of rd_en |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach is the one after the keyboard has been relocated. It only exists once a full four-byte outbound transfer carrying the exact relocate pattern has closed and the responder has finished. The stimulus performs that relocation through the handshake and then queries the new address. The reply must take the five-byte keyboard form, and the old address must now give the three-byte default form. The overrun error follows that short reply: one more acknowledge toggle is sent after the last byte.

// File: rtl/shift_handshake_pkg.sv
package shift_handshake_pkg;
   localparam int NREG     = 16;
   localparam int RIDX_W   = 4;
   localparam int RESP_MAX = 5;
   localparam int ROFF_W   = 3;

   typedef enum logic [3:0] {
      IX_PORTB  = 4'd0,
      IX_PORTA  = 4'd1,
      IX_SHIFT  = 4'd10,
      IX_AUX    = 4'd11,
      IX_FLAGS  = 4'd13,
      IX_ENABLE = 4'd14
   } reg_idx_e;

   // port B bit roles
   localparam int PB_REQN = 3;
   localparam int PB_ACK  = 4;
   localparam int PB_IDLE = 5;
   localparam int PB_ERR  = 7;
   localparam logic [7:0] PB_RESET = 8'h28;

   localparam int FL_SHIFT  = 2;
   localparam int AUX_OUT   = 4;
   localparam int EN_MASTER = 7;

   // indices that are plain read/write storage
   localparam logic [NREG-1:0] PLAIN_MASK = 16'hDBFE;
endpackage

// File: rtl/shift_handshake_plain.sv
module shift_handshake_plain
   import shift_handshake_pkg::*;
#(
   parameter logic [NREG-1:0] MASK = PLAIN_MASK
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [RIDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       q [NREG]
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (MASK[i]) begin : g_store
         logic [7:0] r;
         always_ff @(posedge clk) begin
            if (rst) r <= '0;
            else if (wr_en && idx == RIDX_W'(i)) r <= wdata;
         end
         assign q[i] = r;
      end else begin : g_none
         assign q[i] = '0;
      end
   end
endmodule

// File: rtl/shift_handshake_cmdbuf.sv
module shift_handshake_cmdbuf #(
   parameter int DEPTH = 100,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          push,
   input  logic [7:0]    din,
   output logic [LW-1:0] len,
   output logic          full_drop,
   output logic [7:0]    head [4]
);
   if (DEPTH < 4) begin : g_bad_depth
      $error("command buffer needs at least 4 entries");
   end

   logic [7:0] mem [DEPTH];

   assign full_drop = push && !clr && (len == LW'(DEPTH));

   always_ff @(posedge clk) begin
      if (rst) begin
         len <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         len <= push ? LW'(1) : '0;
         if (push) mem[0] <= din;
      end else if (push && len < LW'(DEPTH)) begin
         mem[len] <= din;
         len      <= len + LW'(1);
      end
   end

   for (genvar h = 0; h < 4; h++) begin : g_head
      assign head[h] = mem[h];
   end

   p_len_bound_r12: assert property (@(posedge clk) disable iff (rst)
      len <= LW'(DEPTH));
endmodule

// File: rtl/shift_handshake_responder.sv
module shift_handshake_responder
   import shift_handshake_pkg::*;
#(
   parameter int         LW       = 7,
   parameter int         RESP_LAT = 4,
   parameter logic [3:0] KBD_INIT = 4'd2,
   localparam int        CW       = $clog2(RESP_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic [LW-1:0]     cmd_len,
   input  logic [7:0]        cmd [4],
   output logic              busy,
   output logic              done,
   output logic [ROFF_W-1:0] resp_len,
   output logic [7:0]        resp [RESP_MAX]
);
   if (RESP_LAT < 1) begin : g_bad_lat
      $error("responder latency must be at least one cycle");
   end

   logic [CW-1:0] cnt;
   logic [7:0]    c0, c1, c2, c3;
   logic          len3, len4;
   logic [3:0]    kbd_q;

   assign done = busy && cnt == '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
         c0 <= '0; c1 <= '0; c2 <= '0; c3 <= '0;
         len3 <= 1'b0; len4 <= 1'b0;
      end else if (go && !busy) begin
         busy <= 1'b1;
         cnt  <= CW'(RESP_LAT - 1);
         c0 <= cmd[0]; c1 <= cmd[1]; c2 <= cmd[2]; c3 <= cmd[3];
         len3 <= cmd_len == LW'(3);
         len4 <= cmd_len >= LW'(4);
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else cnt <= cnt - CW'(1);
      end
   end

   // decode the latched command when the latency expires
   always_ff @(posedge clk) begin
      if (rst) begin
         kbd_q    <= KBD_INIT;
         resp_len <= '0;
         for (int i = 0; i < RESP_MAX; i++) resp[i] <= '0;
      end else if (done) begin
         resp_len <= '0;
         if (c0 == 8'h00 && c1[3:2] == 2'b11) begin
            if (c1[7:4] == kbd_q) begin
               resp[0] <= 8'h01; resp[1] <= 8'h01; resp[2] <= c1;
               resp[3] <= 8'h01; resp[4] <= 8'h01;
               resp_len <= ROFF_W'(5);
            end else begin
               resp[0] <= 8'h00; resp[1] <= 8'h00; resp[2] <= c1;
               resp_len <= ROFF_W'(3);
            end
         end else if (c0 == 8'h00 && c1[3:2] == 2'b10 && len4 &&
                      c1[7:4] == kbd_q && c2[7:4] == 4'h6 && c3 == 8'hFE) begin
            kbd_q <= c2[3:0];
         end else if (c0 == 8'h01 && len3 && c1 == 8'h01 && c2 == 8'h01) begin
            resp[0] <= 8'h00; resp[1] <= 8'h00; resp[2] <= c1;
            resp_len <= ROFF_W'(3);
         end
      end
   end

   p_kbd_stable_r11: assert property (@(posedge clk) disable iff (rst)
      !done |=> $stable(kbd_q));
   p_resp_len_r10: assert property (@(posedge clk) disable iff (rst)
      resp_len <= ROFF_W'(RESP_MAX));
endmodule

// File: rtl/shift_handshake_host.sv
module shift_handshake_host
   import shift_handshake_pkg::*;
#(
   parameter int         ADDR_W    = 13,
   parameter int         IDX_LSB   = 9,
   parameter int         CMD_DEPTH = 100,
   parameter int         RESP_LAT  = 4,
   parameter logic [3:0] KBD_INIT  = 4'd2,
   localparam int        LW        = $clog2(CMD_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq
);
   if (IDX_LSB + RIDX_W > ADDR_W) begin : g_bad_addr
      $error("address too narrow for register index");
   end

   logic [RIDX_W-1:0] idx;
   logic [7:0]        plain_q [NREG];
   logic [7:0]        pb_q, sr_q;
   logic [6:0]        flags_q;
   logic [ROFF_W-1:0] in_off_q, eff_off;
   logic              tip_now, tip_new, ack_now, ack_new;
   logic              wr_pb, start, finish, step, dir_out, in_has, sr_touch, resp_go;
   logic [LW-1:0]     cmd_len;
   logic              cmd_drop;
   logic [7:0]        cmd_head [4];
   logic              resp_busy, resp_done;
   logic [ROFF_W-1:0] resp_len;
   logic [7:0]        resp_bytes [RESP_MAX];

   assign idx = addr[IDX_LSB +: RIDX_W];

   shift_handshake_plain u_plain (
      .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .q(plain_q));

   always_comb begin
      wr_pb    = wr_en && idx == IX_PORTB;
      tip_now  = !pb_q[PB_IDLE];
      ack_now  = pb_q[PB_ACK];
      tip_new  = !wdata[PB_IDLE];
      ack_new  = wdata[PB_ACK];
      start    = wr_pb && tip_new && !tip_now;
      finish   = wr_pb && !tip_new && tip_now;
      step     = start || (wr_pb && (tip_new == tip_now) && (ack_new != ack_now));
      dir_out  = plain_q[IX_AUX][AUX_OUT];
      eff_off  = start ? '0 : in_off_q;
      in_has   = eff_off < resp_len;
      sr_touch = (wr_en || rd_en) && idx == IX_SHIFT;
      resp_go  = finish && cmd_len != '0 && !resp_busy;
   end

   shift_handshake_cmdbuf #(.DEPTH(CMD_DEPTH)) u_cmd (
      .clk(clk), .rst(rst), .clr(start), .push(step && dir_out), .din(sr_q),
      .len(cmd_len), .full_drop(cmd_drop), .head(cmd_head));

   shift_handshake_responder #(.LW(LW), .RESP_LAT(RESP_LAT), .KBD_INIT(KBD_INIT)) u_resp (
      .clk(clk), .rst(rst), .go(resp_go), .cmd_len(cmd_len), .cmd(cmd_head),
      .busy(resp_busy), .done(resp_done), .resp_len(resp_len), .resp(resp_bytes));

   always_ff @(posedge clk) begin
      if (rst) begin
         pb_q     <= PB_RESET;
         sr_q     <= '0;
         flags_q  <= '0;
         in_off_q <= '0;
      end else begin
         if (wr_pb)
            pb_q <= {pb_q[PB_ERR], wdata[6:4], pb_q[PB_REQN], wdata[2:0]};
         if (wr_en && idx == IX_SHIFT) sr_q <= wdata;
         if (wr_en && idx == IX_FLAGS) flags_q <= flags_q & ~wdata[6:0];
         if (sr_touch) flags_q[FL_SHIFT] <= 1'b0;
         if (start) in_off_q <= '0;
         if (step) begin
            flags_q[FL_SHIFT] <= 1'b1;
            if (dir_out) begin
               pb_q[PB_REQN] <= 1'b1;
               if (cmd_drop) pb_q[PB_ERR] <= 1'b1;
            end else if (in_has) begin
               sr_q     <= resp_bytes[eff_off];
               in_off_q <= eff_off + ROFF_W'(1);
               if (eff_off + ROFF_W'(1) == resp_len) pb_q[PB_REQN] <= 1'b1;
            end else begin
               sr_q          <= '0;
               in_off_q      <= eff_off;
               pb_q[PB_ERR]  <= 1'b1;
               pb_q[PB_REQN] <= 1'b1;
            end
         end
         if (resp_done) begin
            pb_q[PB_REQN]     <= 1'b0;
            flags_q[FL_SHIFT] <= 1'b1;
            sr_q              <= '0;
            in_off_q          <= '0;
         end
      end
   end

   always_comb begin
      case (idx)
         IX_PORTB: rdata = pb_q;
         IX_SHIFT: rdata = sr_q;
         IX_FLAGS: rdata = {|flags_q, flags_q};
         default:  rdata = plain_q[idx];
      endcase
   end

   assign irq = plain_q[IX_ENABLE][EN_MASTER] && (|flags_q);

   p_done_pb3_r8: assert property (@(posedge clk) disable iff (rst)
      resp_done |=> !pb_q[PB_REQN] && sr_q == 8'h00);
   p_step_flag_r6: assert property (@(posedge clk) disable iff (rst)
      step |=> flags_q[FL_SHIFT]);
   p_sr_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (sr_touch && !resp_done) |=> !flags_q[FL_SHIFT]);
   p_irq_mask_r5: assert property (@(posedge clk) disable iff (rst)
      !plain_q[IX_ENABLE][EN_MASTER] |-> !irq);
   p_off_bound_r12: assert property (@(posedge clk) disable iff (rst)
      in_off_q <= resp_len);
   p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
      pb_q[PB_ERR] |=> pb_q[PB_ERR]);
endmodule

// File: tb/shift_handshake_host_test.sv
module shift_handshake_host_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [12:0] addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;

   int checks = 0, fails = 0, ack = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   shift_handshake_host uut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .irq(irq));

   // monitor: compares each read against the scoreboard head
   always @(negedge clk) begin
      if (rd_en && !rst) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: got %02h expected nothing", rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (rdata !== e) begin
               fails++;
               $display("FAIL %s: got %02h expected %02h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr(input int i, input logic [7:0] d);
      @(posedge clk); #1;
      addr = 13'(i << 9); wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input int i, input logic [7:0] e, input string t);
      @(posedge clk); #1;
      addr = 13'(i << 9); rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         fails++;
         $display("FAIL %s irq: got %0b expected %0b", t, irq, e);
      end
   endtask

   task automatic send_cmd(input logic [7:0] b0, b1, b2, b3, input int n);
      logic [7:0] b [4];
      b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
      wr(11, 8'h10);
      for (int i = 0; i < n; i++) begin
         wr(10, b[i]);
         if (i == 0) begin ack = 0; wr(0, 8'h00); end
         else begin ack ^= 1; wr(0, ack ? 8'h10 : 8'h00); end
      end
      wr(0, ack ? 8'h30 : 8'h20);
      repeat (12) @(posedge clk);
   endtask

   task automatic rx_start(input logic [7:0] e, input string t);
      wr(11, 8'h00);
      ack = 0;
      wr(0, 8'h00);
      rd(10, e, t);
   endtask

   task automatic rx_next(input logic [7:0] e, input string t);
      ack ^= 1;
      wr(0, ack ? 8'h10 : 8'h00);
      rd(10, e, t);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R2 reset state
      rd(0, 8'h28, "R2 portB");
      rd(13, 8'h00, "R2 flags");
      rd(10, 8'h00, "R2 shift");
      chk_irq(1'b0, "R2");
      // R1 plain storage
      wr(4, 8'hA5); wr(1, 8'h3C);
      rd(4, 8'hA5, "R1 timer");
      rd(1, 8'h3C, "R1 portA");
      rd(5, 8'h00, "R1 neighbour");
      // R5 enable with no flags
      wr(14, 8'h84);
      chk_irq(1'b0, "R5 no flag");
      // R6 first outbound step
      wr(11, 8'h10); wr(10, 8'h00); wr(0, 8'h00);
      rd(13, 8'h84, "R6 flags");
      chk_irq(1'b1, "R5 set");
      rd(0, 8'h08, "R6 portB bit3");
      rd(10, 8'h00, "R4 shift");
      rd(13, 8'h00, "R4 flag cleared");
      chk_irq(1'b0, "R5 cleared");
      // R7 ack toggle steps
      wr(10, 8'h2C); wr(0, 8'h10);
      rd(13, 8'h84, "R7 step");
      wr(13, 8'h04);
      rd(13, 8'h00, "R3 w1c");
      wr(0, 8'h10);
      rd(13, 8'h00, "R7 no change");
      // R13 read-only bit3/bit7
      wr(0, 8'h97);
      rd(0, 8'h1F, "R13 portB");
      // R8 close transfer
      wr(0, 8'h30);
      repeat (12) @(posedge clk);
      rd(0, 8'h30, "R8 portB");
      rd(13, 8'h84, "R8 flags");
      rd(10, 8'h00, "R8 shift");
      // R9/R10 keyboard reply
      wr(13, 8'h7F);
      rx_start(8'h01, "R10 b0");
      rx_next(8'h01, "R10 b1");
      rx_next(8'h2C, "R10 b2");
      rx_next(8'h01, "R10 b3");
      rd(0, 8'h10, "R9 not last");
      rx_next(8'h01, "R9 b4");
      rd(0, 8'h08, "R9 last");
      wr(0, 8'h20);
      rd(0, 8'h28, "R9 closed");
      // R11 relocate keyboard to 5
      send_cmd(8'h00, 8'h2A, 8'h65, 8'hFE, 4);
      rd(0, 8'h30, "R11 reply ready");
      send_cmd(8'h00, 8'h5C, 8'h00, 8'h00, 2);
      rx_start(8'h01, "R11 b0");
      rx_next(8'h01, "R11 b1");
      rx_next(8'h5C, "R11 b2");
      wr(0, 8'h20);
      // R10 default reply at old address, then R12 overrun
      send_cmd(8'h00, 8'h2C, 8'h00, 8'h00, 2);
      rx_start(8'h00, "R10 d0");
      rx_next(8'h00, "R10 d1");
      rx_next(8'h2C, "R10 d2");
      rd(0, 8'h08, "R9 short last");
      rx_next(8'h00, "R12 past end");
      rd(0, 8'h98, "R12 error bit");
      wr(0, 8'h20);
      rd(0, 8'hA8, "R12 sticky");
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule